// File: doc/BRIEF.md
# Verified Byte Programming Sequencer

The block is a host-side controller that writes a run of bytes into a command-driven flash device. Each byte is programmed with a pulse-and-verify loop. For each byte the block issues a program-setup command. It then writes the address and data, waits a fixed program interval, and issues a program-verify command. After a fixed verify interval it reads the byte back over the flash bus and compares it with the source byte. A mismatch repeats the pulse. A byte that still mismatches after the attempt limit stops the run with a failure.

The run starts at address 0 and covers `count_i` bytes. The data source is addressed by `fl_addr_o`. It must return the byte for that address on `src_data_i` and hold it stable while the run is on that address.

A masked mode is selected by `mask_i` when the run starts. It exists for setups where several devices share one bus and a device that has already verified must not be pulsed again. In this mode the block replaces the commands with harmless codes and treats every byte as passed.

Top module: `fpgm_seq`

## Requirements
- R1: After reset the bus is idle: `fl_ce_n_o`, `fl_we_n_o` and `fl_oe_n_o` are 1, `fl_dq_oe_o` is 0, `fl_addr_o` is 0, and `done_o` and `fail_o` are 0.
- R2: Each bus write holds `fl_we_n_o` low for WE_CYC cycles and then high for one cycle. During all WE_CYC+1 cycles, `fl_ce_n_o` is 0, `fl_dq_oe_o` is 1, and the address and data do not change.
- R3: Each attempt runs in this order: a write of 40h, a write of the source byte to the current address, the program wait, a write of C0h, the verify wait, a read with `fl_oe_n_o` low for RD_CYC cycles, and then one compare cycle with all strobes high.
- R4: The program wait lasts CLK_MHZ*PROG_US cycles and the verify wait lasts CLK_MHZ*VER_US cycles. During both waits `fl_ce_n_o` is 0 and every other strobe is high.
- R5: The block never drives the data bus while `fl_oe_n_o` is low. `fl_we_n_o` and `fl_oe_n_o` are never low together.
- R6: When the read-back byte equals the source byte, the block moves to the next address and starts its attempt count from zero. A pass on address `count_i`-1 ends the run.
- R7: On a mismatch the attempt repeats. If the byte has already received MAX_TRY (20) pulses, the run stops with a failure instead.
- R8: `done_o` is high for exactly the one cycle after a run ends, and the bus is idle in that cycle. `fail_o` rises in that cycle when the run failed. It stays high until the next start is accepted, which clears it.
- R9: A start with `count_i` = 0 produces the `done_o` pulse in the next cycle, with no bus activity and `fail_o` at 0.
- R10: A run started with `mask_i` = 1 writes FFh as the setup command, FFh as the data, and 00h as the verify command. Each byte gets exactly one attempt and passes.
- R11: `start_i` has no effect while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a run (accepted when idle) |
| count_i | input | ADDR_W+1 | Number of bytes to program |
| mask_i | input | 1 | Masked mode for the run |
| src_data_i | input | 8 | Source byte for the address on fl_addr_o |
| fl_addr_o | output | ADDR_W | Flash address, 0 when idle |
| fl_dq_o | output | 8 | Data driven onto the flash bus |
| fl_dq_oe_o | output | 1 | Drive enable for fl_dq_o |
| fl_dq_i | input | 8 | Data read from the flash bus |
| fl_ce_n_o | output | 1 | Chip enable, active low |
| fl_oe_n_o | output | 1 | Output enable, active low |
| fl_we_n_o | output | 1 | Write enable, active low |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| fail_o | output | 1 | Run failed; held until the next start |

## Verification
A wrong sequencer state shows on the strobes in the very cycle it occurs. A skipped or misordered step puts the wrong command byte on the bus, or drops `fl_we_n_o` or `fl_oe_n_o` in the wrong cycle. A miscounted wait moves every later edge by the error, so the per-cycle comparison flags it on the first shifted edge. A wrong attempt count or compare result stays hidden until the next compare cycle. It then shows as an extra or a missing attempt, or as `done_o` and `fail_o` arriving one attempt early or late.

// File: rtl/fpgm_pkg.sv
package fpgm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_C1_LO, ST_C1_HI, ST_C2_LO, ST_C2_HI, ST_PWAIT,
    ST_C3_LO, ST_C3_HI, ST_VWAIT, ST_RD, ST_CHK
  } st_e;

  localparam logic [7:0] CMD_SETUP   = 8'h40;
  localparam logic [7:0] CMD_VERIFY  = 8'hC0;
  localparam logic [7:0] CMD_MSETUP  = 8'hFF;
  localparam logic [7:0] CMD_MDATA   = 8'hFF;
  localparam logic [7:0] CMD_MVERIFY = 8'h00;

  function automatic st_e st_succ(st_e s);
    case (s)
      ST_C1_LO: return ST_C1_HI;
      ST_C1_HI: return ST_C2_LO;
      ST_C2_LO: return ST_C2_HI;
      ST_C2_HI: return ST_PWAIT;
      ST_PWAIT: return ST_C3_LO;
      ST_C3_LO: return ST_C3_HI;
      ST_C3_HI: return ST_VWAIT;
      ST_VWAIT: return ST_RD;
      ST_RD:    return ST_CHK;
      default:  return ST_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/fpgm_tmr.sv
module fpgm_tmr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fpgm_vchk.sv
module fpgm_vchk (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cap_i,
  input  logic [7:0] rd_i,
  input  logic [7:0] exp_i,
  input  logic       bypass_i,
  output logic       match_o
);
  logic [7:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rd_q <= '0;
    else if (cap_i) rd_q <= rd_i;
  end

  // masked runs never compare
  assign match_o = bypass_i | (rd_q == exp_i);
endmodule

// File: rtl/fpgm_seq.sv
module fpgm_seq
  import fpgm_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int CLK_MHZ = 200,
  parameter int PROG_US = 25,
  parameter int VER_US  = 6,
  parameter int WE_CYC  = 4,
  parameter int RD_CYC  = 4,
  parameter int MAX_TRY = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W:0]   count_i,
  input  logic              mask_i,
  input  logic [7:0]        src_data_i,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_dq_o,
  output logic              fl_dq_oe_o,
  input  logic [7:0]        fl_dq_i,
  output logic              fl_ce_n_o,
  output logic              fl_oe_n_o,
  output logic              fl_we_n_o,
  output logic              done_o,
  output logic              fail_o
);
  localparam int PROG_CYC = CLK_MHZ * PROG_US;
  localparam int VER_CYC  = CLK_MHZ * VER_US;
  localparam int TW       = $clog2(PROG_CYC + VER_CYC + WE_CYC + RD_CYC + 1);
  localparam int CW       = ADDR_W + 1;
  localparam int YW       = $clog2(MAX_TRY + 1);

  st_e st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [CW-1:0]     cnt_q;
  logic [YW-1:0]     try_q;
  logic              mask_q, done_q, fail_q;
  logic              adv, run_start, done_set, fail_set, addr_inc;
  logic              tmr_zero, match, last;

  function automatic logic [TW-1:0] len_m1(st_e s);
    case (s)
      ST_C1_LO, ST_C2_LO, ST_C3_LO: return TW'(WE_CYC - 1);
      ST_PWAIT: return TW'(PROG_CYC - 1);
      ST_VWAIT: return TW'(VER_CYC - 1);
      ST_RD:    return TW'(RD_CYC - 1);
      default:  return '0;
    endcase
  endfunction

  fpgm_tmr #(.W(TW)) u_tmr (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(adv),
    .val_i (len_m1(st_d)), .zero_o(tmr_zero)
  );

  fpgm_vchk u_vchk (
    .clk_i   (clk_i), .rst_ni(rst_ni),
    .cap_i   (st_q == ST_RD && tmr_zero),
    .rd_i    (fl_dq_i), .exp_i(src_data_i),
    .bypass_i(mask_q), .match_o(match)
  );

  assign last = (({1'b0, addr_q} + CW'(1)) == cnt_q);

  always_comb begin
    st_d = st_q; adv = 1'b0; run_start = 1'b0;
    done_set = 1'b0; fail_set = 1'b0; addr_inc = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        run_start = 1'b1;
        if (count_i != '0) begin st_d = ST_C1_LO; adv = 1'b1; end
        else done_set = 1'b1;
      end
      ST_CHK: begin
        adv = 1'b1;
        if (match) begin
          if (last) begin st_d = ST_IDLE; done_set = 1'b1; end
          else begin st_d = ST_C1_LO; addr_inc = 1'b1; end
        end else if (try_q == YW'(MAX_TRY)) begin
          st_d = ST_IDLE; done_set = 1'b1; fail_set = 1'b1;
        end else st_d = ST_C1_LO;
      end
      default: if (tmr_zero) begin adv = 1'b1; st_d = st_succ(st_q); end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; addr_q <= '0; cnt_q <= '0; try_q <= '0;
      mask_q <= 1'b0; done_q <= 1'b0; fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_set;
      if (run_start) begin
        addr_q <= '0; cnt_q <= count_i; mask_q <= mask_i;
        try_q <= '0; fail_q <= 1'b0;
      end else begin
        if (addr_inc) begin addr_q <= addr_q + 1'b1; try_q <= '0; end
        else if (st_q == ST_C2_HI && tmr_zero) try_q <= try_q + 1'b1;
        if (fail_set) fail_q <= 1'b1;
      end
    end
  end

  logic wr_lo, wr_any;
  assign wr_lo  = (st_q == ST_C1_LO) || (st_q == ST_C2_LO) || (st_q == ST_C3_LO);
  assign wr_any = wr_lo || (st_q == ST_C1_HI) || (st_q == ST_C2_HI) || (st_q == ST_C3_HI);

  always_comb begin
    case (st_q)
      ST_C1_LO, ST_C1_HI: fl_dq_o = mask_q ? CMD_MSETUP  : CMD_SETUP;
      ST_C2_LO, ST_C2_HI: fl_dq_o = mask_q ? CMD_MDATA   : src_data_i;
      ST_C3_LO, ST_C3_HI: fl_dq_o = mask_q ? CMD_MVERIFY : CMD_VERIFY;
      default:            fl_dq_o = 8'h00;
    endcase
  end

  assign fl_ce_n_o  = (st_q == ST_IDLE);
  assign fl_we_n_o  = !wr_lo;
  assign fl_oe_n_o  = (st_q != ST_RD);
  assign fl_dq_oe_o = wr_any;
  assign fl_addr_o  = (st_q == ST_IDLE) ? '0 : addr_q;
  assign done_o     = done_q;
  assign fail_o     = fail_q;

  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!fl_we_n_o && !fl_oe_n_o));
  assert_read_hiz_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_oe_n_o |-> !fl_dq_oe_o);
  assert_we_ce_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_we_n_o |-> !fl_ce_n_o);
  assert_wr_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_we_n_o |=> $stable(fl_addr_o) && $stable(fl_dq_o) && fl_dq_oe_o);
  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> fl_ce_n_o);
  assert_fail_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !start_i |=> fail_o);
  assert_try_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    try_q <= YW'(MAX_TRY));
  assert_chk_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_CHK |-> tmr_zero);
  assert_busy_ignore_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_ce_n_o && start_i && st_q != ST_CHK |=> !fl_ce_n_o);
endmodule

// File: tb/fpgm_seq_tb.sv
module fpgm_seq_tb;
  localparam int AW = 4, MHZ = 1, PUS = 25, VUS = 6, WEC = 2, RDC = 2, MAXT = 20;
  localparam int PCYC = MHZ * PUS, VCYC = MHZ * VUS;

  logic clk = 0, rst_ni = 0, start_i = 0, mask_i = 0;
  logic [AW:0] count_i = '0;
  logic [AW-1:0] fl_addr_o;
  logic [7:0] fl_dq_o, fl_dq_i, src_data;
  logic fl_dq_oe_o, fl_ce_n_o, fl_oe_n_o, fl_we_n_o, done_o, fail_o;

  int checks = 0, failures = 0;
  int need [16];
  int pulses [16];
  logic [7:0] src_mem [16];
  logic [7:0] fcmd = 8'h00;
  logic prev_we = 1'b1;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign src_data = src_mem[fl_addr_o];
  assign fl_dq_i  = (fcmd == 8'hC0) ?
    ((pulses[fl_addr_o] >= need[fl_addr_o]) ? src_mem[fl_addr_o] : (src_mem[fl_addr_o] & 8'h0F))
    : src_mem[fl_addr_o];

  fpgm_seq #(.ADDR_W(AW), .CLK_MHZ(MHZ), .PROG_US(PUS), .VER_US(VUS),
             .WE_CYC(WEC), .RD_CYC(RDC), .MAX_TRY(MAXT)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .count_i(count_i),
    .mask_i(mask_i), .src_data_i(src_data), .fl_addr_o(fl_addr_o),
    .fl_dq_o(fl_dq_o), .fl_dq_oe_o(fl_dq_oe_o), .fl_dq_i(fl_dq_i),
    .fl_ce_n_o(fl_ce_n_o), .fl_oe_n_o(fl_oe_n_o), .fl_we_n_o(fl_we_n_o),
    .done_o(done_o), .fail_o(fail_o));

  // behavioural flash: latches a write on the rising write strobe
  always @(negedge clk) begin
    if (!prev_we && fl_we_n_o) begin
      if (fcmd == 8'h40) begin
        if (fl_dq_o != 8'hFF) pulses[fl_addr_o] = pulses[fl_addr_o] + 1;
        fcmd = 8'h00;
      end else fcmd = fl_dq_o;
    end
    prev_we = fl_we_n_o;
  end

  task automatic chk1(string rq, bit ce, bit we, bit oe, bit doe, logic [7:0] dq,
                      logic [AW-1:0] ad, bit dn, bit fl);
    logic [7:0] adq;
    logic [AW+13:0] act, exp;
    adq = doe ? fl_dq_o : 8'h00;
    act = {fl_ce_n_o, fl_we_n_o, fl_oe_n_o, fl_dq_oe_o, adq, fl_addr_o, done_o, fail_o};
    exp = {ce, we, oe, doe, dq, ad, dn, fl};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%h expected=%h", rq, $time, act, exp);
    end
  endtask

  task automatic span(int n, string rq, bit we, bit oe, bit doe, logic [7:0] dq, logic [AW-1:0] ad);
    for (int i = 0; i < n; i++) begin
      chk1(rq, 1'b0, we, oe, doe, dq, ad, 1'b0, 1'b0);
      @(negedge clk);
    end
  endtask

  task automatic wr(string rq, logic [7:0] dq, logic [AW-1:0] ad);
    span(WEC, rq, 1'b0, 1'b1, 1'b1, dq, ad);
    span(1, rq, 1'b1, 1'b1, 1'b1, dq, ad);
  endtask

  // expected bus trace for a whole run, starting at the first cycle after start
  task automatic model_run(int cnt, bit msk);
    bit failed = 0;
    for (int a = 0; a < cnt && !failed; a++) begin
      for (int att = 1; att <= MAXT; att++) begin
        wr("R3", msk ? 8'hFF : 8'h40, a[AW-1:0]);
        wr(msk ? "R10" : "R2", msk ? 8'hFF : src_mem[a], a[AW-1:0]);
        span(PCYC, "R4", 1'b1, 1'b1, 1'b0, 8'h00, a[AW-1:0]);
        wr("R3", msk ? 8'h00 : 8'hC0, a[AW-1:0]);
        span(VCYC, "R4", 1'b1, 1'b1, 1'b0, 8'h00, a[AW-1:0]);
        span(RDC, "R5", 1'b1, 1'b0, 1'b0, 8'h00, a[AW-1:0]);
        span(1, "R3", 1'b1, 1'b1, 1'b0, 8'h00, a[AW-1:0]);
        if (msk || att >= need[a]) break;
        if (att == MAXT) failed = 1;
      end
    end
    chk1(failed ? "R7" : "R8", 1, 1, 1, 0, 8'h00, '0, 1'b1, failed);
    @(negedge clk);
    chk1("R8", 1, 1, 1, 0, 8'h00, '0, 1'b0, failed);
  endtask

  task automatic kick(int cnt, bit msk);
    for (int i = 0; i < 16; i++) pulses[i] = 0;
    @(negedge clk);
    count_i = cnt[AW:0]; mask_i = msk; start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      need[i] = 1; pulses[i] = 0;
      src_mem[i] = 8'hC3 ^ 8'(i * 7);
    end
    repeat (3) @(negedge clk);
    chk1("R1", 1, 1, 1, 0, 8'h00, '0, 0, 0);
    rst_ni = 1;
    @(negedge clk);
    chk1("R1", 1, 1, 1, 0, 8'h00, '0, 0, 0);

    // R6 / R3: three bytes, middle one needs three pulses; R11 start pulse mid-run
    need[1] = 3;
    kick(3, 0);
    fork
      model_run(3, 0);
      begin
        repeat (40) @(negedge clk);
        start_i = 1; count_i = 1;
        @(negedge clk);
        start_i = 0;
      end
    join

    // R7: byte 2 never verifies -> fail after MAXT pulses, byte 3 untouched
    need[1] = 1; need[2] = MAXT + 5;
    kick(4, 0);
    model_run(4, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk1("R8", 1, 1, 1, 0, 8'h00, '0, 0, 1);
    end
    checks++;
    if (pulses[2] != MAXT) begin
      failures++;
      $display("FAIL R7 pulses actual=%0d expected=%0d", pulses[2], MAXT);
    end

    // R9: zero count, also clears fail (R8)
    @(negedge clk);
    count_i = 0; start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk1("R9", 1, 1, 1, 0, 8'h00, '0, 1, 0);
    @(negedge clk);
    chk1("R9", 1, 1, 1, 0, 8'h00, '0, 0, 0);

    // R10: masked run passes on one attempt despite unprogrammable bytes
    need[0] = 30; need[1] = 30;
    kick(2, 1);
    model_run(2, 1);
    checks++;
    if (pulses[0] != 0) begin
      failures++;
      $display("FAIL R10 pulses actual=%0d expected=0", pulses[0]);
    end

    // R6: full address range, last byte needs two pulses
    for (int i = 0; i < 16; i++) need[i] = 1;
    need[15] = 2;
    kick(16, 0);
    model_run(16, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule